// File: doc/BRIEF.md
# Dual-Mode Integer / Single-Precision Multiplier

This block multiplies two operand words in either of two modes, selected per transaction by a mode input. In integer mode the low 24 bits of each word are taken as unsigned numbers and the full 48-bit product is returned. In float mode each 32-bit word is read as sign, 8-bit biased exponent and 23-bit fraction. The result word carries the product's sign, exponent and a truncated 23-bit fraction. Results are returned in the low 32 bits, and an exception flag is raised for any case outside the supported subset.

The 24x24 core is split into four 12x12 quadrant multipliers. Each quadrant multiplies one half of A by one half of B, and the four partial products are shifted and added. A width checker looks at the upper half of each significand. When that half is zero, it switches off every quadrant that would use it, and the disabled quadrants feed zero into the sum. The checker's enables are registered together with the operands.

The block is a three-stage pipeline with a valid/ready handshake on both sides. All stages advance together whenever the output register is empty or being drained.

Top module: `dmm_mult`

## Requirements
- R1: During and right after synchronous reset, out_valid is 0 and in_ready is 1.
- R2: With mode_fp=0, result equals op_a[23:0] times op_b[23:0] as a 48-bit unsigned product, and op bits 31:24 have no effect.
- R3: The integer product is exact when the upper 12 bits of either or both operands are zero. A quadrant whose enable is low delivers a zero partial product.
- R4: With mode_fp=1, result bit 31 is the XOR of op_a bit 31 and op_b bit 31.
- R5: With mode_fp=1, result bits 30:23 are the low 8 bits of ea+eb-127. One more is added when bit 47 of the significand product is set. Here ea and eb are operand bits 30:23.
- R6: With mode_fp=1, the significands are {1,op[22:0]}. If product bit 47 is set, result bits 22:0 are product bits 46:24; otherwise they are bits 45:23. Result bits 47:32 are 0.
- R7: out_exc is 1 in float mode when either input exponent field is 0 or 255, or when the result exponent lies outside 1..254. It is always 0 in integer mode.
- R8: While out_valid is 1 and out_ready is 0, result and out_valid hold and in_ready is 0.
- R9: Each accepted operand pair yields exactly one result, in order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block accepts the pair this cycle |
| mode_fp | input | 1 | 1 = single-precision float, 0 = integer |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 48 | Integer product, or packed float in bits 31:0 |
| out_exc | output | 1 | Float case outside supported subset |

## Verification
A stuck or mis-timed quadrant enable appears at the ports as a product that is wrong by a multiple of 2^12 or 2^24. It shows up on the very transaction whose operand half it touches, so the operand sweep pairs zero, one, all-ones and top-bit halves in every combination. A wrong normalisation decision shows as a fraction shifted by one place together with an exponent off by one, in the same result. Pipeline-control faults show as a lost, duplicated or changed result during a stall. The bench catches these within a few cycles through its in-order scoreboard and its hold check.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int EXT_W  = EXP_W + 2;

  typedef struct packed {
    logic             sign;
    logic [EXT_W-1:0] exp;   // two's complement, bias already removed once
    logic             exc;
  } fp_side_t;
endpackage

// File: rtl/dmm_width_check.sv
module dmm_width_check #(
  parameter int HALF_W = 12
) (
  input  logic [2*HALF_W-1:0] sig_a,
  input  logic [2*HALF_W-1:0] sig_b,
  output logic [3:0]          quad_en
);
  logic a_wide, b_wide;

  always_comb begin
    a_wide     = |sig_a[2*HALF_W-1:HALF_W];
    b_wide     = |sig_b[2*HALF_W-1:HALF_W];
    quad_en[0] = 1'b1;              // low x low
    quad_en[1] = a_wide;            // high A x low B
    quad_en[2] = b_wide;            // low A x high B
    quad_en[3] = a_wide & b_wide;   // high x high
  end
endmodule

// File: rtl/dmm_quad_mult.sv
module dmm_quad_mult #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         en,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  always_ff @(posedge clk) begin
    if (rst)
      p <= '0;
    else if (adv)
      p <= en ? (PW'(x) * PW'(y)) : '0;
  end
endmodule

// File: rtl/dmm_fp_pack.sv
module dmm_fp_pack
  import dmm_pkg::*;
#(
  parameter int PROD_W = 48
) (
  input  logic              mode_fp,
  input  logic [PROD_W-1:0] prod,
  input  fp_side_t          side,
  output logic [PROD_W-1:0] res,
  output logic              exc
);
  localparam int EXP_TOP = (1 << EXP_W) - 2;

  logic              norm;
  logic [FRAC_W-1:0] frac;
  logic [EXT_W-1:0]  exp_f;
  logic              range_bad;

  always_comb begin
    norm      = prod[PROD_W-1];
    frac      = norm ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
    exp_f     = side.exp + EXT_W'(norm);
    range_bad = ($signed(exp_f) < 1) || ($signed(exp_f) > EXP_TOP);
    if (mode_fp) begin
      res = PROD_W'({side.sign, exp_f[EXP_W-1:0], frac});
      exc = side.exc | range_bad;
    end else begin
      res = prod;
      exc = 1'b0;
    end
  end
endmodule

// File: rtl/dmm_mult.sv
module dmm_mult
  import dmm_pkg::*;
#(
  parameter int HALF_W = SIG_W / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  mode_fp,
  input  logic [WORD_W-1:0]     op_a,
  input  logic [WORD_W-1:0]     op_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [4*HALF_W-1:0]   result,
  output logic                  out_exc
);
  localparam int OP_W   = 2 * HALF_W;
  localparam int PROD_W = 2 * OP_W;
  localparam int QP_W   = 2 * HALF_W;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage 0: unpack
  logic [OP_W-1:0] sig_a, sig_b;
  logic [3:0]      en0;
  fp_side_t        side0;
  logic [EXP_W-1:0] ea, eb;

  always_comb begin
    ea = op_a[WORD_W-2 -: EXP_W];
    eb = op_b[WORD_W-2 -: EXP_W];
    if (mode_fp) begin
      sig_a = OP_W'({1'b1, op_a[FRAC_W-1:0]});
      sig_b = OP_W'({1'b1, op_b[FRAC_W-1:0]});
    end else begin
      sig_a = op_a[OP_W-1:0];
      sig_b = op_b[OP_W-1:0];
    end
    side0.sign = op_a[WORD_W-1] ^ op_b[WORD_W-1];
    side0.exp  = EXT_W'(ea) + EXT_W'(eb) - EXT_W'(BIAS);
    side0.exc  = (ea == '0) || (ea == EXP_ONES) || (eb == '0) || (eb == EXP_ONES);
  end

  dmm_width_check #(.HALF_W(HALF_W)) u_wchk (
    .sig_a  (sig_a),
    .sig_b  (sig_b),
    .quad_en(en0)
  );

  // stage 1 registers
  logic            v1, mode1;
  logic [OP_W-1:0] a1, b1;
  logic [3:0]      en1;
  fp_side_t        side1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; mode1 <= 1'b0; a1 <= '0; b1 <= '0; en1 <= '0; side1 <= '0;
    end else if (adv) begin
      v1    <= in_valid;
      mode1 <= mode_fp;
      a1    <= sig_a;
      b1    <= sig_b;
      en1   <= en0;
      side1 <= side0;
    end
  end

  // stage 2: quadrant products (index bit0 = A half, bit1 = B half)
  logic [QP_W-1:0] qp [4];

  for (genvar qi = 0; qi < 4; qi++) begin : g_quad
    dmm_quad_mult #(.W(HALF_W)) u_q (
      .clk(clk),
      .rst(rst),
      .adv(adv),
      .en (en1[qi]),
      .x  (a1[(qi % 2)*HALF_W +: HALF_W]),
      .y  (b1[(qi / 2)*HALF_W +: HALF_W]),
      .p  (qp[qi])
    );
  end

  logic [QP_W-1:0] p_hl, p_lh, p_hh;
  assign p_hl = qp[1];
  assign p_lh = qp[2];
  assign p_hh = qp[3];

  logic     v2, mode2;
  fp_side_t side2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; mode2 <= 1'b0; side2 <= '0;
    end else if (adv) begin
      v2    <= v1;
      mode2 <= mode1;
      side2 <= side1;
    end
  end

  // stage 3: combine and pack
  logic [PROD_W-1:0] prod2, packed2;
  logic              exc2;

  always_comb begin
    prod2 = PROD_W'(qp[0])
          + ((PROD_W'(qp[1]) + PROD_W'(qp[2])) << HALF_W)
          + (PROD_W'(qp[3]) << OP_W);
  end

  dmm_fp_pack #(.PROD_W(PROD_W)) u_pack (
    .mode_fp(mode2),
    .prod   (prod2),
    .side   (side2),
    .res    (packed2),
    .exc    (exc2)
  );

  logic mode3;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; result <= '0; out_exc <= 1'b0; mode3 <= 1'b0;
    end else if (adv) begin
      out_valid <= v2;
      result    <= packed2;
      out_exc   <= exc2;
      mode3     <= mode2;
    end
  end
endmodule

// File: rtl/dmm_checker.sv
module dmm_checker #(
  parameter int HALF_W = 12,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [4*HALF_W-1:0] result,
  input logic                out_exc,
  input logic                mode3,
  input logic                adv,
  input logic [3:0]          en1,
  input logic [2*HALF_W-1:0] p_hl,
  input logic [2*HALF_W-1:0] p_lh,
  input logic [2*HALF_W-1:0] p_hh
);
  localparam int PROD_W = 4 * HALF_W;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result)); // R8
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_INT_NO_EXC: assert property (@(posedge clk) disable iff (rst)
    out_valid && !mode3 |-> !out_exc); // R7
  AST_FP_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && mode3 |-> result[PROD_W-1:WORD_W] == '0); // R6
  AST_GATE_HL: assert property (@(posedge clk) disable iff (rst)
    adv && !en1[1] |=> p_hl == '0); // R3
  AST_GATE_LH: assert property (@(posedge clk) disable iff (rst)
    adv && !en1[2] |=> p_lh == '0); // R3
  AST_GATE_HH: assert property (@(posedge clk) disable iff (rst)
    adv && !en1[3] |=> p_hh == '0); // R3
endmodule

bind dmm_mult dmm_checker #(.HALF_W(HALF_W), .WORD_W(dmm_pkg::WORD_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .result(result), .out_exc(out_exc), .mode3(mode3),
  .adv(adv), .en1(en1), .p_hl(p_hl), .p_lh(p_lh), .p_hh(p_hh)
);

// File: tb/dmm_mult_tb.sv
module dmm_mult_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        mode_fp = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [47:0] result;
  logic        out_exc;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dmm_mult u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode_fp(mode_fp), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .out_exc(out_exc)
  );

  logic [48:0] q_exp[$];
  logic        q_mode[$];
  string       q_tag[$];
  int          sent = 0, got = 0;
  logic        pend = 1'b0;
  logic        pm;
  logic [31:0] pa, pb;
  logic        stall_mode = 1'b0;
  logic        prev_stall = 1'b0;
  logic [47:0] prev_res = '0;

  function automatic logic [48:0] model(input logic m, input logic [31:0] a, input logic [31:0] b);
    logic [47:0] p;
    int          e;
    logic        x;
    logic [22:0] f;
    if (!m) return {1'b0, 48'(a[23:0]) * 48'(b[23:0])};
    p = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin e = e + 1; f = p[46:24]; end
    else f = p[45:23];
    x = (a[30:23] == 8'd0) || (a[30:23] == 8'd255) || (b[30:23] == 8'd0) ||
        (b[30:23] == 8'd255) || (e < 1) || (e > 254);
    return {x, 16'h0, a[31] ^ b[31], e[7:0], f};
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cycle();
    logic [48:0] e;
    logic        m;
    string       t;
    @(negedge clk);
    out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
    in_valid  = pend;
    mode_fp   = pm;
    op_a      = pa;
    op_b      = pb;
    #1;
    if (prev_stall) begin
      check("R8 hold valid", 48'(out_valid), 48'd1);
      check("R8 hold result", result, prev_res);
    end
    prev_stall = out_valid && !out_ready;
    prev_res   = result;
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) begin
        check("R9 extra result", 48'd1, 48'd0);
      end else begin
        e = q_exp.pop_front(); m = q_mode.pop_front(); t = q_tag.pop_front();
        got++;
        if (!m) begin
          check(t, result, e[47:0]);
          check("R7 int flag", 48'(out_exc), 48'd0);
        end else begin
          check("R4 sign", 48'(result[31]), 48'(e[31]));
          check("R5 exponent", 48'(result[30:23]), 48'(e[30:23]));
          check("R6 fraction", {result[47:32], 9'd0, result[22:0]}, {e[47:32], 9'd0, e[22:0]});
          check("R7 exc flag", 48'(out_exc), 48'(e[48]));
        end
      end
    end
    if (in_valid && in_ready) begin
      q_exp.push_back(model(pm, pa, pb));
      q_mode.push_back(pm);
      q_tag.push_back(t_next);
      sent++;
      pend = 1'b0;
    end
  endtask

  string t_next = "R2";

  task automatic send(input logic m, input logic [31:0] a, input logic [31:0] b, input string t);
    pm = m; pa = a; pb = b; t_next = t; pend = 1'b1;
    while (pend) cycle();
  endtask

  task automatic drain();
    pend = 1'b0;
    for (int i = 0; i < 20; i++) cycle();
  endtask

  function automatic logic [31:0] fpw(input logic s, input logic [7:0] e, input logic [22:0] f);
    return {s, e, f};
  endfunction

  initial begin
    logic [11:0] hv [4];
    hv[0] = 12'h000; hv[1] = 12'h001; hv[2] = 12'hfff; hv[3] = 12'h800;
    pm = 1'b0; pa = '0; pb = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset valid", 48'(out_valid), 48'd0);
    check("R1 reset ready", 48'(in_ready), 48'd1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle valid", 48'(out_valid), 48'd0);

    // R3: every combination of upper/lower halves from a corner set
    for (int i = 0; i < 256; i++)
      send(1'b0, {8'h00, hv[i % 4], hv[(i / 4) % 4]},
                 {8'h00, hv[(i / 16) % 4], hv[i / 64]}, "R3");
    // R2: junk in bits 31:24 must not matter
    for (int i = 0; i < 1500; i++)
      send(1'b0, $urandom, $urandom, "R2");
    send(1'b0, 32'hffffffff, 32'hffffffff, "R2");

    // float corners: R4 R5 R6 R7
    send(1'b1, fpw(0, 8'd127, 23'd0), fpw(1, 8'd127, 23'd0), "F");
    send(1'b1, fpw(1, 8'd127, 23'h7fffff), fpw(1, 8'd127, 23'h7fffff), "F");
    send(1'b1, fpw(0, 8'd0, 23'h1), fpw(0, 8'd130, 23'h0), "F");
    send(1'b1, fpw(0, 8'd255, 23'h0), fpw(0, 8'd100, 23'h0), "F");
    send(1'b1, fpw(0, 8'd200, 23'h0), fpw(0, 8'd200, 23'h0), "F");
    send(1'b1, fpw(0, 8'd10, 23'h0), fpw(0, 8'd10, 23'h0), "F");
    send(1'b1, fpw(0, 8'd64, 23'h0), fpw(0, 8'd64, 23'h0), "F");
    send(1'b1, fpw(0, 8'd191, 23'h7fffff), fpw(0, 8'd191, 23'h0), "F");
    for (int i = 0; i < 1500; i++)
      send(1'b1, $urandom, $urandom, "F");

    // R8/R9: random backpressure, mixed modes
    stall_mode = 1'b1;
    for (int i = 0; i < 800; i++)
      send(1'($urandom % 2), $urandom, $urandom, "R9 mixed");
    stall_mode = 1'b0;
    drain();
    check("R9 count", 48'(got), 48'(sent));
    check("R9 queue empty", 48'(q_exp.size()), 48'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule